// File: doc/BRIEF.md
# LCD vertical timing generator

This block produces the frame-level timing of an LCD panel. It counts line periods, signalled by a one-cycle `line_end` pulse from the horizontal timing logic, and steps each frame through four phases in a fixed order. First comes a back porch of blank lines, then the active lines, then a front porch of blank lines, and last a sync or extra-wait phase. After that phase it moves straight into the back porch of the next frame. A line period keeps running during every blank phase, so every `line_end` pulse advances the count, whatever the phase.

A 32-bit configuration word sets the length of each phase, and a mode bit picks thin-film (TFT) or passive panel behaviour. The word and the mode are taken in the clock edge at which the block leaves its idle state, and they stay frozen for as long as it stays enabled. Software may change them only while the block is disabled.

In TFT mode, vertical sync stays high for the whole sync phase. In passive mode, the same field only lengthens the frame with extra blank line periods, and vertical sync is high for just the first of those periods. The outputs also give an active-line flag, the index of the current active line, and a one-cycle frame-start pulse.

Top module: `lcd_vtiming_gen`

## Requirements
- R1: After reset and while `enable` is low, `vsync`, `line_active` and `frame_start` are 0 and `line_index` is 0. One clock edge after `enable` is seen low, the block is idle.
- R2: The fields of `cfg_word` are: lines per panel minus one in bits 9:0, sync count minus one in bits 15:10, front porch in bits 23:16, back porch in bits 31:24. The word and `tft_mode` are captured at the edge that starts a frame from idle. Changes to either while enabled have no effect on the outputs.
- R3: On the edge where the block is idle and `enable` is high, a frame starts. `frame_start` is high for exactly the following cycle.
- R4: The back porch lasts (bits 31:24) line periods, with `line_active` and `vsync` low. A value of 0 skips it, so the frame opens with active line 0.
- R5: The active phase lasts (bits 9:0)+1 line periods, with `line_active` high. `line_index` starts at 0 and rises by one on each `line_end`.
- R6: The front porch lasts (bits 23:16) line periods, with `line_active` and `vsync` low. A value of 0 skips it.
- R7: With `tft_mode`=1 captured, `vsync` is high for (bits 15:10)+1 line periods right after the front porch.
- R8: With `tft_mode`=0 captured, the sync phase still lasts (bits 15:10)+1 line periods, but `vsync` is high only during its first line period.
- R9: After the sync phase the next frame begins at its back porch, or at active line 0 if the back porch is 0. `frame_start` is high for the one cycle after the `line_end` that ends the sync phase.
- R10: Outputs change only in the cycle after a `line_end` pulse, or on a start from idle or a disable. A cycle without `line_end` leaves them unchanged.
- R11: Dropping `enable` for one edge in the middle of a frame abandons that frame. Raising it again starts a new frame from its back porch, using the configuration present at that edge.
- R12: `line_index` is 0 whenever `line_active` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| enable | input | 1 | Runs the frame sequence when high, idles when low |
| tft_mode | input | 1 | 1 = TFT panel, 0 = passive panel; captured at frame start from idle |
| cfg_word | input | 32 | Porch, sync and line-count fields; captured at frame start from idle |
| line_end | input | 1 | One-cycle pulse at the end of each line period |
| vsync | output | 1 | Vertical sync |
| line_active | output | 1 | High during active lines |
| line_index | output | 10 | Index of the current active line, 0 otherwise |
| frame_start | output | 1 | One-cycle pulse when a frame begins |

## Verification
The assertions check on every cycle the rules that need only a few cycles of history. These are:
- the outputs are quiet after a disable;
- the outputs hold between `line_end` pulses;
- the active index steps by one and never passes the captured line count;
- vsync never overlaps active lines;
- a passive-mode sync lasts one line period;
- `frame_start` lasts a single cycle.

Phase lengths, skipped porches, wrapping into the next frame, field positions, and the fact that configuration written while running is ignored all depend on whole frames of counting. Only the bench's scenarios can show these, by comparing each cycle against a frame-position model.

// File: rtl/lcd_vt_pkg.sv
package lcd_vt_pkg;

  localparam int unsigned LPP_W = 10;
  localparam int unsigned SW_W  = 6;
  localparam int unsigned FP_W  = 8;
  localparam int unsigned BP_W  = 8;

  localparam int unsigned LPP_LSB = 0;
  localparam int unsigned SW_LSB  = LPP_LSB + LPP_W;
  localparam int unsigned FP_LSB  = SW_LSB + SW_W;
  localparam int unsigned BP_LSB  = FP_LSB + FP_W;
  localparam int unsigned CFG_W   = BP_LSB + BP_W;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Phase counter must hold the longest phase length minus one
  localparam int unsigned CNT_W = max2(max2(LPP_W, SW_W), max2(FP_W, BP_W));

  typedef logic [CNT_W-1:0] vt_cnt_t;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_BACK   = 3'd1,
    PH_ACTIVE = 3'd2,
    PH_FRONT  = 3'd3,
    PH_SYNC   = 3'd4
  } vt_phase_e;

  typedef struct packed {
    logic [BP_W-1:0]  bp;
    logic [FP_W-1:0]  fp;
    logic [SW_W-1:0]  sw;
    logic [LPP_W-1:0] lpp;
    logic             tft;
  } vt_cfg_t;

endpackage

// File: rtl/lcd_vt_cfg_reg.sv
module lcd_vt_cfg_reg
  import lcd_vt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CFG_W-1:0] cfg_word,
  input  logic             tft_mode,
  output vt_cfg_t          cfg_eff,
  output vt_cfg_t          cfg_q
);

  vt_cfg_t cfg_live;

  always_comb begin
    cfg_live.bp  = cfg_word[BP_LSB  +: BP_W];
    cfg_live.fp  = cfg_word[FP_LSB  +: FP_W];
    cfg_live.sw  = cfg_word[SW_LSB  +: SW_W];
    cfg_live.lpp = cfg_word[LPP_LSB +: LPP_W];
    cfg_live.tft = tft_mode;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (load) begin
      cfg_q <= cfg_live;
    end
  end

  // The start edge uses the live word; the rest of the run uses the frozen copy
  assign cfg_eff = load ? cfg_live : cfg_q;

endmodule

// File: rtl/lcd_vt_seq.sv
module lcd_vt_seq
  import lcd_vt_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      enable,
  input  logic      line_end,
  input  vt_cfg_t   cfg,
  output vt_phase_e phase_q,
  output vt_cnt_t   cnt_q,
  output logic      frame_start_q,
  output logic      load
);

  vt_phase_e phase_d;
  vt_cnt_t   cnt_d;
  logic      fs_d;
  logic      adv_en;
  vt_cnt_t   last_cnt;
  vt_phase_e first_ph;
  vt_phase_e after_ph;
  logic      at_last;

  assign load = enable && (phase_q == PH_IDLE);

  // Skip an empty back porch
  assign first_ph = (cfg.bp != '0) ? PH_BACK : PH_ACTIVE;

  always_comb begin
    last_cnt = '0;
    after_ph = PH_IDLE;
    unique case (phase_q)
      PH_BACK: begin
        last_cnt = vt_cnt_t'(cfg.bp) - vt_cnt_t'(1);
        after_ph = PH_ACTIVE;
      end
      PH_ACTIVE: begin
        last_cnt = vt_cnt_t'(cfg.lpp);
        after_ph = (cfg.fp != '0) ? PH_FRONT : PH_SYNC;
      end
      PH_FRONT: begin
        last_cnt = vt_cnt_t'(cfg.fp) - vt_cnt_t'(1);
        after_ph = PH_SYNC;
      end
      PH_SYNC: begin
        last_cnt = vt_cnt_t'(cfg.sw);
        after_ph = first_ph;
      end
      default: begin
        last_cnt = '0;
        after_ph = first_ph;
      end
    endcase
  end

  assign at_last = (cnt_q == last_cnt);

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    fs_d    = 1'b0;
    if (!enable) begin
      phase_d = PH_IDLE;
      cnt_d   = '0;
    end else if (phase_q == PH_IDLE) begin
      phase_d = first_ph;
      cnt_d   = '0;
      fs_d    = 1'b1;
    end else if (line_end) begin
      if (at_last) begin
        phase_d = after_ph;
        cnt_d   = '0;
        fs_d    = (phase_q == PH_SYNC);
      end else begin
        cnt_d = cnt_q + vt_cnt_t'(1);
      end
    end
  end

  // State moves only on a line-end, a start or a disable
  assign adv_en = !enable || (phase_q == PH_IDLE) || line_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else if (adv_en) begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_start_q <= 1'b0;
    end else begin
      frame_start_q <= fs_d;
    end
  end

endmodule

// File: rtl/lcd_vt_out.sv
module lcd_vt_out
  import lcd_vt_pkg::*;
(
  input  vt_phase_e        phase_q,
  input  vt_cnt_t          cnt_q,
  input  logic             tft,
  output logic             vsync,
  output logic             line_active,
  output logic [LPP_W-1:0] line_index
);

  logic in_sync;
  logic first_line;

  assign in_sync     = (phase_q == PH_SYNC);
  assign first_line  = (cnt_q == '0);
  assign line_active = (phase_q == PH_ACTIVE);

  // TFT: whole sync phase; passive: first line period of it only
  assign vsync       = in_sync && (tft || first_line);
  assign line_index  = line_active ? cnt_q[LPP_W-1:0] : '0;

endmodule

// File: rtl/lcd_vtiming_gen.sv
module lcd_vtiming_gen
  import lcd_vt_pkg::*;
#(
  parameter int unsigned RST_STAGES = 2
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             tft_mode,
  input  logic [CFG_W-1:0] cfg_word,
  input  logic             line_end,
  output logic             vsync,
  output logic             line_active,
  output logic [LPP_W-1:0] line_index,
  output logic             frame_start
);

  logic [RST_STAGES-1:0] rst_pipe;
  logic                  rst_n_int;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[RST_STAGES-2:0], 1'b1};
    end
  end
  assign rst_n_int = rst_pipe[RST_STAGES-1];

  vt_cfg_t   cfg_eff;
  vt_cfg_t   cfg_q;
  vt_phase_e phase_w;
  vt_cnt_t   cnt_w;
  logic      load_w;

  lcd_vt_cfg_reg u_cfg (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .load     (load_w),
    .cfg_word (cfg_word),
    .tft_mode (tft_mode),
    .cfg_eff  (cfg_eff),
    .cfg_q    (cfg_q)
  );

  lcd_vt_seq u_seq (
    .clk           (clk),
    .rst_n         (rst_n_int),
    .enable        (enable),
    .line_end      (line_end),
    .cfg           (cfg_eff),
    .phase_q       (phase_w),
    .cnt_q         (cnt_w),
    .frame_start_q (frame_start),
    .load          (load_w)
  );

  lcd_vt_out u_out (
    .phase_q     (phase_w),
    .cnt_q       (cnt_w),
    .tft         (cfg_q.tft),
    .vsync       (vsync),
    .line_active (line_active),
    .line_index  (line_index)
  );

endmodule

// File: rtl/lcd_vt_checker.sv
module lcd_vt_checker
  import lcd_vt_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic             line_end,
  input logic             vsync,
  input logic             line_active,
  input logic [LPP_W-1:0] line_index,
  input logic             frame_start,
  input vt_phase_e        phase_q,
  input logic             tft_q,
  input logic [LPP_W-1:0] lpp_q
);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!vsync && !line_active && !frame_start));

  a_r12_index_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !line_active |-> (line_index == '0));

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !line_end && phase_q != PH_IDLE)
      |=> ($stable(line_index) && $stable(line_active) && $stable(vsync)));

  a_r5_index_step: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && line_active && line_end)
      |=> (!line_active || (line_index == $past(line_index) + 1'b1)));

  a_r5_index_bound: assert property (@(posedge clk) disable iff (!rst_n)
    line_active |-> (line_index <= lpp_q));

  a_r3_fs_single: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !frame_start);

  a_r7_vsync_blank: assert property (@(posedge clk) disable iff (!rst_n)
    vsync |-> !line_active);

  a_r8_passive_one: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && vsync && !tft_q && line_end) |=> !vsync);

endmodule

bind lcd_vtiming_gen lcd_vt_checker u_vt_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .enable      (enable),
  .line_end    (line_end),
  .vsync       (vsync),
  .line_active (line_active),
  .line_index  (line_index),
  .frame_start (frame_start),
  .phase_q     (phase_w),
  .tft_q       (cfg_q.tft),
  .lpp_q       (cfg_q.lpp)
);

// File: tb/lcd_vtiming_gen_bench.sv
`timescale 1ns/1ps
module lcd_vtiming_gen_bench;

  logic        clk;
  logic        rst_n;
  logic        enable;
  logic        tft_mode;
  logic [31:0] cfg_word;
  logic        line_end;
  logic        vsync;
  logic        line_active;
  logic [9:0]  line_index;
  logic        frame_start;

  int nchk  = 0;
  int nfail = 0;

  // Bench model state
  bit running;
  int n;
  bit exp_fs;
  int c_bp, c_fp, c_sw, c_lpp;
  bit c_tft;
  bit scrambled;

  lcd_vtiming_gen u_lcd_vtiming_gen (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .tft_mode    (tft_mode),
    .cfg_word    (cfg_word),
    .line_end    (line_end),
    .vsync       (vsync),
    .line_active (line_active),
    .line_index  (line_index),
    .frame_start (frame_start)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] pack_cfg(int bp, int fp, int sw, int lpp);
    return {bp[7:0], fp[7:0], sw[5:0], lpp[9:0]};
  endfunction

  // Expected outputs at position p (line-end pulses since frame start)
  // ph: 1 back, 2 active, 3 front, 4 sync
  function automatic void decode(input int p, output int ph, output int vs,
                                 output int act, output int idx);
    int q;
    q = p; vs = 0; act = 0; idx = 0;
    if (q < c_bp) begin ph = 1; return; end
    q -= c_bp;
    if (q < c_lpp + 1) begin ph = 2; act = 1; idx = q; return; end
    q -= c_lpp + 1;
    if (q < c_fp) begin ph = 3; return; end
    q -= c_fp;
    ph = 4;
    vs = c_tft ? 1 : ((q == 0) ? 1 : 0);
  endfunction

  task automatic step(bit le);
    int period, ph, vs, act, idx;
    string tag;
    line_end = le;
    @(posedge clk);
    if (!enable) begin
      running = 0; exp_fs = 0;
    end else if (!running) begin
      running = 1; n = 0; exp_fs = 1;
      c_bp  = int'(cfg_word[31:24]);
      c_fp  = int'(cfg_word[23:16]);
      c_sw  = int'(cfg_word[15:10]);
      c_lpp = int'(cfg_word[9:0]);
      c_tft = tft_mode;
    end else if (le) begin
      n++;
      period = c_bp + c_lpp + 1 + c_fp + c_sw + 1;
      exp_fs = ((n % period) == 0);
    end else begin
      exp_fs = 0;
    end
    @(negedge clk);
    if (!running) begin
      ph = 0; vs = 0; act = 0; idx = 0;
    end else begin
      period = c_bp + c_lpp + 1 + c_fp + c_sw + 1;
      decode(n % period, ph, vs, act, idx);
    end
    case (ph)
      0: tag = "R1 R11 idle";
      1: tag = "R4 back porch";
      2: tag = "R5 active";
      3: tag = "R6 front porch";
      default: tag = c_tft ? "R7 tft sync" : "R8 passive sync";
    endcase
    if (!le && running) tag = {tag, " R10"};
    if (scrambled) tag = {tag, " R2"};
    chk({tag, " vsync"}, int'(vsync), vs);
    chk({tag, " line_active"}, int'(line_active), act);
    chk({tag, " R12 line_index"}, int'(line_index), idx);
    chk({tag, (n > 0) ? " R9" : " R3", " frame_start"}, int'(frame_start), int'(exp_fs));
  endtask

  // mode 0: line_end every cycle; 1: random; 2: every third cycle
  task automatic run_cfg(int bp, int fp, int sw, int lpp, bit tft,
                         int cycles, int mode, bit drop, bit scramble);
    bit le;
    enable = 0; scrambled = 0;
    step(0);
    cfg_word = pack_cfg(bp, fp, sw, lpp);
    tft_mode = tft;
    enable = 1;
    step(0);
    if (scramble) begin
      cfg_word = $urandom;
      tft_mode = ~tft;
      scrambled = 1;
    end
    for (int i = 0; i < cycles; i++) begin
      case (mode)
        0: le = 1;
        1: le = $urandom_range(0, 1) == 1;
        default: le = (i % 3) == 0;
      endcase
      if (drop && i == cycles / 2) begin
        // R11: one-edge disable mid-frame, then restart with a new word
        enable = 0;
        scrambled = 0;
        step(le);
        cfg_word = pack_cfg(bp + 1, fp, sw, lpp);
        tft_mode = tft;
        enable = 1;
      end else begin
        step(le);
      end
    end
    enable = 0;
    scrambled = 0;
    step(0);
  endtask

  initial begin
    void'($urandom(32'h0001CD57));
    rst_n = 0; enable = 0; tft_mode = 0; cfg_word = '0; line_end = 0;
    running = 0; n = 0; exp_fs = 0; scrambled = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset vsync", int'(vsync), 0);
    chk("R1 reset line_active", int'(line_active), 0);
    chk("R1 reset line_index", int'(line_index), 0);
    chk("R1 reset frame_start", int'(frame_start), 0);
    rst_n = 1;
    repeat (4) step(0);

    // Directed corners
    run_cfg(0, 0, 0, 0, 1, 12, 0, 0, 0);   // R4 R6 shortest frame, tft
    run_cfg(0, 0, 0, 0, 0, 12, 1, 0, 0);   // shortest frame, passive
    run_cfg(2, 3, 4, 5, 0, 60, 0, 0, 1);   // R8 long passive sync, R2 scramble
    run_cfg(1, 0, 2, 3, 1, 40, 2, 0, 1);   // R7 no front porch
    run_cfg(0, 2, 1, 2, 1, 40, 1, 1, 0);   // R11 drop mid frame
    run_cfg(255, 255, 63, 1023, 1, 1700, 0, 0, 1); // maximum field values
    run_cfg(3, 1, 63, 1023, 0, 1200, 0, 0, 0);

    // Random configurations
    for (int k = 0; k < 60; k++) begin
      run_cfg($urandom_range(0, 5), $urandom_range(0, 5), $urandom_range(0, 3),
              $urandom_range(0, 9), $urandom_range(0, 1) == 1,
              $urandom_range(40, 160), $urandom_range(0, 2),
              $urandom_range(0, 3) == 0, $urandom_range(0, 1) == 1);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule